// File: doc/BRIEF.md
# Combined Read-Modify-Write ALU

This unit computes the fused memory-modify-then-accumulator operations of a classic 8-bit processor core. For each operation it first changes a fetched memory byte: it increments, decrements, shifts or rotates it. It then feeds the changed byte into a second step on the accumulator: compare, subtract, AND, add, OR or XOR. One further operation writes the accumulator ANDed with the X register to memory. For each operation the block returns the byte to write back to memory, the new accumulator and the updated carry, zero, negative and overflow flags.

The core presents one operation per cycle on a valid strobe. The results appear on registered outputs on the next clock edge. The core's sequencer decides when to drive the returned byte onto the memory bus. All arithmetic is binary. A single shared adder carries out the compare, the subtract and the add.

Top module: `rmw_alu`

## Requirements
- R1: Decrement-compare (code 0): the written byte is the operand minus 1, modulo 256. The accumulator and overflow are left unchanged. Carry is set when the new byte is less than or equal to the accumulator. Zero is set when the two are equal. Negative is bit 7 of the accumulator minus the new byte.
- R2: Increment-subtract (code 1): the written byte is the operand plus 1, modulo 256. The accumulator becomes the low byte of accumulator + inverted byte + carry-in, and carry is set when no borrow occurs. Overflow is set when the accumulator and the inverted byte have equal sign bits and the result's sign bit differs from the accumulator's. Negative and zero follow the result.
- R3: Rotate-left-AND (code 2): the written byte is the operand rotated left through carry: old bit 7 goes to carry and the old carry goes to bit 0. The accumulator becomes the accumulator AND the written byte. Negative and zero follow the new accumulator.
- R4: Rotate-right-add (code 3): the written byte is the operand rotated right through carry: old bit 0 goes to the new carry and the old carry goes to bit 7. The accumulator becomes the low byte of accumulator + written byte + new carry. Carry is set when that sum exceeds 255, and overflow follows the signed-addition rule. Negative and zero follow the result.
- R5: Store-AND (code 4): the written byte is the accumulator AND X. The accumulator and all flags keep their input values.
- R6: Shift-left-OR (code 5): the written byte is the operand shifted left, with 0 entering bit 0 and old bit 7 going to carry. The accumulator becomes the accumulator OR the written byte. Negative and zero follow the new accumulator.
- R7: Shift-right-XOR (code 6): the written byte is the operand shifted right, with 0 entering bit 7 and old bit 0 going to carry. The accumulator becomes the accumulator XOR the written byte. Negative and zero follow the new accumulator.
- R8: Every flag that an operation does not name is returned equal to its input value. Code 7 is a no-operation: it leaves the accumulator and all four flags at their input values.
- R9: Results appear on the clock edge after a valid strobe, with out_valid high for that one cycle. out_wr is high in that same cycle for codes 0 to 6 and low for code 7. Both are low after a cycle without a strobe.
- R10: While reset is asserted, out_valid and out_wr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code 0..7 |
| in_mem | input | 8 | Fetched memory byte |
| in_acc | input | 8 | Accumulator |
| in_x | input | 8 | X index register |
| in_c | input | 1 | Carry in |
| in_z | input | 1 | Zero in |
| in_n | input | 1 | Negative in |
| in_v | input | 1 | Overflow in |
| out_valid | output | 1 | Result valid |
| out_wr | output | 1 | Memory write enable |
| out_mem | output | 8 | Byte to write back |
| out_acc | output | 8 | New accumulator |
| out_c | output | 1 | Carry out |
| out_z | output | 1 | Zero out |
| out_n | output | 1 | Negative out |
| out_v | output | 1 | Overflow out |

## Verification
Every result is due exactly one clock edge after its strobe: the write-back byte, the accumulator, the flags, out_valid and out_wr all pass through a single register stage. The driver applies each operation at a falling edge and queues the expected result. The monitor samples at the following falling edge and pops one item for every out_valid it sees. An early, late or missing result therefore shows up as a queue mismatch. Idle cycles are mixed into the stream to check that out_valid and out_wr stay low when no strobe was given.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_DECCMP = 3'd0,
        OP_INCSUB = 3'd1,
        OP_ROLAND = 3'd2,
        OP_RORADD = 3'd3,
        OP_STAND  = 3'd4,
        OP_SHLOR  = 3'd5,
        OP_SHRXOR = 3'd6,
        OP_NONE   = 3'd7
    } rmw_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } flags_t;

endpackage

// File: rtl/rmw_modify.sv
// First stage: alters the fetched memory operand.
module rmw_modify
    import rmw_pkg::*;
#(
    parameter int W = 8
) (
    input  rmw_op_e        op,
    input  logic [W-1:0]   mem,
    input  logic           c_in,
    output logic [W-1:0]   mod,
    output logic           c_mod,
    output logic           wr_req
);
    localparam int MSB = W - 1;

    always_comb begin
        mod    = mem;
        c_mod  = c_in;
        wr_req = (op != OP_NONE);
        case (op)
            OP_DECCMP: mod = mem - W'(1);
            OP_INCSUB: mod = mem + W'(1);
            OP_ROLAND: begin
                mod   = {mem[MSB-1:0], c_in};
                c_mod = mem[MSB];
            end
            OP_RORADD: begin
                mod   = {c_in, mem[MSB:1]};
                c_mod = mem[0];
            end
            OP_SHLOR: begin
                mod   = {mem[MSB-1:0], 1'b0};
                c_mod = mem[MSB];
            end
            OP_SHRXOR: begin
                mod   = {1'b0, mem[MSB:1]};
                c_mod = mem[0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rmw_adder.sv
// Shared binary adder with carry-out and signed-overflow detect.
module rmw_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = full[MSB:0];
        cout = full[W];
        ovf  = ~(a[MSB] ^ b[MSB]) & (a[MSB] ^ full[MSB]);
    end
endmodule

// File: rtl/rmw_accstep.sv
// Second stage: applies the accumulator step to the modified byte.
module rmw_accstep
    import rmw_pkg::*;
#(
    parameter int W = 8
) (
    input  rmw_op_e        op,
    input  logic [W-1:0]   acc,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   mod,
    input  logic           c_mod,
    input  flags_t         f_in,
    output logic [W-1:0]   acc_out,
    output logic [W-1:0]   wdata,
    output flags_t         f_out
);
    localparam int MSB = W - 1;

    logic [W-1:0] add_b;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_ovf;
    logic         nz_upd;

    // Operand select for the single shared adder
    always_comb begin
        add_b   = ~mod;
        add_cin = 1'b1;
        if (op == OP_INCSUB) begin
            add_cin = f_in.c;
        end else if (op == OP_RORADD) begin
            add_b   = mod;
            add_cin = c_mod;
        end
    end

    rmw_adder #(.W(W)) add_i (
        .a    (acc),
        .b    (add_b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    always_comb begin
        acc_out = acc;
        wdata   = mod;
        f_out   = f_in;
        nz_upd  = 1'b0;
        case (op)
            OP_DECCMP: begin
                f_out.c = add_cout;
                f_out.z = (add_sum == '0);
                f_out.n = add_sum[MSB];
            end
            OP_INCSUB, OP_RORADD: begin
                acc_out = add_sum;
                f_out.c = add_cout;
                f_out.v = add_ovf;
                nz_upd  = 1'b1;
            end
            OP_ROLAND: begin
                acc_out = acc & mod;
                f_out.c = c_mod;
                nz_upd  = 1'b1;
            end
            OP_SHLOR: begin
                acc_out = acc | mod;
                f_out.c = c_mod;
                nz_upd  = 1'b1;
            end
            OP_SHRXOR: begin
                acc_out = acc ^ mod;
                f_out.c = c_mod;
                nz_upd  = 1'b1;
            end
            OP_STAND: wdata = acc & x;
            default: ;
        endcase
        if (nz_upd) begin
            f_out.z = (acc_out == '0);
            f_out.n = acc_out[MSB];
        end
    end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [2:0]   in_op,
    input  logic [W-1:0] in_mem,
    input  logic [W-1:0] in_acc,
    input  logic [W-1:0] in_x,
    input  logic         in_c,
    input  logic         in_z,
    input  logic         in_n,
    input  logic         in_v,
    output logic         out_valid,
    output logic         out_wr,
    output logic [W-1:0] out_mem,
    output logic [W-1:0] out_acc,
    output logic         out_c,
    output logic         out_z,
    output logic         out_n,
    output logic         out_v
);
    typedef struct packed {
        logic         vld;
        logic         wr;
        logic [W-1:0] mem;
        logic [W-1:0] acc;
        flags_t       f;
    } res_t;

    res_t         res_d, res_q;
    rmw_op_e      op_w;
    flags_t       f_in_w, f_out_w;
    logic [W-1:0] mod_w, acc_w, wdat_w;
    logic         cmod_w, wreq_w;

    assign op_w   = rmw_op_e'(in_op);
    assign f_in_w = '{c: in_c, z: in_z, n: in_n, v: in_v};

    rmw_modify #(.W(W)) mod_i (
        .op     (op_w),
        .mem    (in_mem),
        .c_in   (in_c),
        .mod    (mod_w),
        .c_mod  (cmod_w),
        .wr_req (wreq_w)
    );

    rmw_accstep #(.W(W)) acc_i (
        .op      (op_w),
        .acc     (in_acc),
        .x       (in_x),
        .mod     (mod_w),
        .c_mod   (cmod_w),
        .f_in    (f_in_w),
        .acc_out (acc_w),
        .wdata   (wdat_w),
        .f_out   (f_out_w)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        res_d.wr  = in_valid & wreq_w;
        if (in_valid) begin
            res_d.mem = wdat_w;
            res_d.acc = acc_w;
            res_d.f   = f_out_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign out_wr    = res_q.wr;
    assign out_mem   = res_q.mem;
    assign out_acc   = res_q.acc;
    assign out_c     = res_q.f.c;
    assign out_z     = res_q.f.z;
    assign out_n     = res_q.f.n;
    assign out_v     = res_q.f.v;
endmodule

// File: rtl/rmw_alu_chk.sv
module rmw_alu_chk
    import rmw_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [2:0]   in_op,
    input logic [W-1:0] in_mem,
    input logic [W-1:0] in_acc,
    input logic [W-1:0] in_x,
    input logic         in_c,
    input logic         in_z,
    input logic         in_n,
    input logic         in_v,
    input logic         out_valid,
    input logic         out_wr,
    input logic [W-1:0] out_mem,
    input logic [W-1:0] out_acc,
    input logic         out_c,
    input logic         out_z,
    input logic         out_n,
    input logic         out_v
);
    localparam int MSB = W - 1;

    // R9
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wr));

    // R9
    write_for_real_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != OP_NONE) |=> out_wr);

    // R8
    noop_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_NONE) |=>
            (!out_wr && out_acc == $past(in_acc) && out_c == $past(in_c)));

    // R5
    store_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_STAND) |=>
            (out_mem == $past(in_acc & in_x) && out_acc == $past(in_acc)
             && out_c == $past(in_c) && out_z == $past(in_z)
             && out_n == $past(in_n) && out_v == $past(in_v)));

    // R1
    deccmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_DECCMP) |=>
            (out_acc == $past(in_acc) && out_v == $past(in_v)));

    // R6
    shl_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_SHLOR) |=> (out_c == $past(in_mem[MSB])));

    // R7
    shr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_SHRXOR) |=> (out_c == $past(in_mem[0])));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_wr));
endmodule

bind rmw_alu rmw_alu_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_mem    (in_mem),
    .in_acc    (in_acc),
    .in_x      (in_x),
    .in_c      (in_c),
    .in_z      (in_z),
    .in_n      (in_n),
    .in_v      (in_v),
    .out_valid (out_valid),
    .out_wr    (out_wr),
    .out_mem   (out_mem),
    .out_acc   (out_acc),
    .out_c     (out_c),
    .out_z     (out_z),
    .out_n     (out_n),
    .out_v     (out_v)
);

// File: tb/rmw_alu_tb_top.sv
module rmw_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        int         op;
        logic [7:0] acc;
        logic [7:0] mem;
        logic       wr;
        logic [3:0] f;     // {c,z,n,v}
        logic [3:0] keep;  // flags that must equal the inputs
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_op = '0;
    logic [7:0] in_mem = '0, in_acc = '0, in_x = '0;
    logic       in_c = 1'b0, in_z = 1'b0, in_n = 1'b0, in_v = 1'b0;
    logic       out_valid, out_wr, out_c, out_z, out_n, out_v;
    logic [7:0] out_mem, out_acc;

    int   total = 0;
    int   bad = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rmw_alu #(.W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_mem(in_mem), .in_acc(in_acc), .in_x(in_x),
        .in_c(in_c), .in_z(in_z), .in_n(in_n), .in_v(in_v),
        .out_valid(out_valid), .out_wr(out_wr), .out_mem(out_mem),
        .out_acc(out_acc), .out_c(out_c), .out_z(out_z),
        .out_n(out_n), .out_v(out_v)
    );

    function automatic string op_tag(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic exp_t model(int op, int a, int m, int x, int c, logic [3:0] fin);
        exp_t e;
        int m2, s, nc;
        e.op = op; e.acc = 8'(a); e.mem = 8'(m); e.wr = (op != 7);
        e.f = fin; e.keep = 4'b1111;
        case (op)
            0: begin
                m2 = (m + 255) % 256; s = (a - m2 + 256) % 256;
                e.mem = 8'(m2);
                e.f[3] = (m2 <= a); e.f[2] = (a == m2); e.f[1] = (s >= 128);
                e.keep = 4'b0001;
            end
            1: begin
                m2 = (m + 1) % 256; s = a + (255 - m2) + c;
                e.mem = 8'(m2); e.acc = 8'(s % 256);
                e.f[3] = (s > 255);
                e.f[0] = (((a ^ m2) & (a ^ s) & 128) != 0);
                e.keep = 4'b0000;
            end
            2: begin
                nc = m / 128; m2 = ((m * 2) % 256) | c;
                e.mem = 8'(m2); e.acc = 8'(a & m2); e.f[3] = nc[0];
                e.keep = 4'b0001;
            end
            3: begin
                nc = m % 2; m2 = (m / 2) | (c * 128); s = a + m2 + nc;
                e.mem = 8'(m2); e.acc = 8'(s % 256); e.f[3] = (s > 255);
                e.f[0] = ((~(a ^ m2) & (a ^ s) & 128) != 0);
                e.keep = 4'b0000;
            end
            4: e.mem = 8'(a & x);
            5: begin
                m2 = (m * 2) % 256;
                e.mem = 8'(m2); e.acc = 8'(a | m2); e.f[3] = (m >= 128);
                e.keep = 4'b0001;
            end
            6: begin
                m2 = m / 2;
                e.mem = 8'(m2); e.acc = 8'(a ^ m2); e.f[3] = (m % 2 == 1);
                e.keep = 4'b0001;
            end
            default: ;
        endcase
        if (op == 1 || op == 2 || op == 3 || op == 5 || op == 6) begin
            e.f[2] = (e.acc == 8'h00);
            e.f[1] = e.acc[7];
        end
        return e;
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Monitor: pops one expected item per valid result
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            logic [3:0] got_f, chg;
            exp_t e;
            got_f = {out_c, out_z, out_n, out_v};
            if (out_valid) begin
                total++;
                if (sb.size() == 0) begin
                    bad++;
                    $display("FAIL R9: result without strobe, got valid=1 expected valid=0");
                end else begin
                    e = sb.pop_front();
                    // R9: write enable per operation
                    if (out_wr !== e.wr) begin
                        bad++;
                        $display("FAIL R9: op %0d wr got %b expected %b", e.op, out_wr, e.wr);
                    end
                    // R1..R7: modified byte, accumulator, updated flags
                    total++;
                    chg = ~e.keep;
                    if ((out_acc !== e.acc) || (e.wr && out_mem !== e.mem)
                        || ((got_f & chg) !== (e.f & chg))) begin
                        bad++;
                        $display("FAIL %s: op %0d got acc=%h mem=%h f=%b expected acc=%h mem=%h f=%b",
                                 op_tag(e.op), e.op, out_acc, out_mem, got_f & chg,
                                 e.acc, e.mem, e.f & chg);
                    end
                    // R8: flags not named by the operation keep their inputs
                    if (e.keep != 4'b0000) begin
                        total++;
                        if ((got_f & e.keep) !== (e.f & e.keep)) begin
                            bad++;
                            $display("FAIL R8: op %0d kept flags got %b expected %b",
                                     e.op, got_f & e.keep, e.f & e.keep);
                        end
                    end
                end
            end else if (out_wr) begin
                total++;
                bad++;
                $display("FAIL R9: wr without valid, got wr=1 expected wr=0");
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run still busy, got hang expected end");
            finish_run();
        end
    end

    // Driver
    initial begin
        int accs[5];
        int xs[5];
        int step;
        accs = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h5A};
        xs   = '{8'hFF, 8'h0F, 8'hA5, 8'h00, 8'h3C};
        step = 0;
        repeat (3) @(negedge clk);
        // R10: outputs quiet while reset is held
        total++;
        if (out_valid !== 1'b0 || out_wr !== 1'b0) begin
            bad++;
            $display("FAIL R10: reset got valid=%b wr=%b expected 0 0", out_valid, out_wr);
        end
        rst_n = 1'b1;
        mon_en = 1'b1;
        for (int op = 0; op < 8; op++) begin
            for (int ai = 0; ai < 5; ai++) begin
                for (int m = 0; m < 256; m++) begin
                    for (int c = 0; c < 2; c++) begin
                        logic [3:0] fin;
                        @(negedge clk);
                        step++;
                        if (step % 37 == 0) begin
                            in_valid = 1'b0;   // idle cycle: R9
                            @(negedge clk);
                        end
                        fin = {c[0], m[2], m[3] ^ ai[0], m[1]};
                        in_valid = 1'b1;
                        in_op  = 3'(op);
                        in_mem = 8'(m);
                        in_acc = 8'(accs[ai]);
                        in_x   = 8'(xs[ai]);
                        {in_c, in_z, in_n, in_v} = fin;
                        sb.push_back(model(op, accs[ai], m, xs[ai], c, fin));
                    end
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R9: every strobe produced exactly one result
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R9: pending results got %0d expected 0", sb.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule